// File: doc/BRIEF.md
# Configurable-Latency Address Parity Checker

This block guards the address and command lines that a memory module register captures. In each selected cycle it folds the checked data bits into a single parity bit. It waits for the parity bit that the memory controller sends one or two cycles later, and XORs the two. The result is driven on a partial-parity output, and an active-low error flag drops whenever that result is 1. Once the flag drops it stays low for a fixed hold period.

A one-bit role input picks the parity arrival delay. A standalone device, or the front device of a cascaded pair, expects the parity bit one cycle after its data. The back device expects it two cycles after. In a pair, the front device's partial-parity output feeds the back device's parity input. The block follows the same dual chip-select gating as the data register it sits beside, and an asynchronous active-low reset clears it.

Top module: `addr_parity_checker`

## Requirements
- R1: While `rst_n` is low, `ppo` is 0 and `err_n` is 1, and this takes effect at once without waiting for a clock edge. The hold counter and the delay pipeline are also cleared.
- R2: With `role_back` = 0, data sampled at edge k is matched with `par_in` sampled at edge k+1. After edge k+1, `ppo` equals the XOR of the checked data bits and `par_in`. For example, an even count of ones with `par_in` = 0 gives 0, and an odd count with `par_in` = 0 gives 1.
- R3: With `role_back` = 1, data sampled at edge k is matched with `par_in` sampled at edge k+2, and `ppo` updates after edge k+2.
- R4: `err_n` goes low at the edge that follows a `ppo` update whose value is 1, and stays high after a `ppo` update of 0. The error therefore appears two edges after its data when `role_back` = 0 and three edges after when `role_back` = 1.
- R5: Once low, `err_n` stays low for exactly two enabled edges and then returns high. A new error detected while it is low restarts the two-edge hold.
- R6: At any edge where `cs_a_n` and `cs_b_n` are both 1, `ppo`, `err_n` and the hold count keep their values.
- R7: Data bits 0, 3 and 6 of `data_in` do not enter the parity; the checked mask is 14'h3FB6.
- R8: Data sampled at an edge where both chip selects are 1 is never compared. At the edge where its parity bit would arrive, `ppo` keeps its value and no error can follow from it.
- R9: Asserting `rst_n` low while `err_n` is low drives `err_n` high at once, without waiting for the hold to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| role_back | input | 1 | 0: standalone or front device (1-cycle parity delay); 1: back device (2-cycle delay) |
| cs_a_n | input | 1 | First chip select, active low |
| cs_b_n | input | 1 | Second chip select, active low |
| data_in | input | 14 | Registered address/command bits; bits 0, 3, 6 unchecked |
| par_in | input | 1 | Parity bit from the controller, or from the front device's `ppo` |
| ppo | output | 1 | Partial parity: XOR of the checked data bits and the matching `par_in` |
| err_n | output | 1 | Parity error flag, active low, held for two edges |

## Verification
A table of cycles is run once in each role. It mixes data with even and odd counts of checked ones, both values of `par_in`, and rows in which one, both or neither chip select is low. Agreement with the model across both runs separates the one-cycle delay from the two-cycle delay and a clean compare from a failing one. Directed sequences then use data made only of the unchecked bits 0, 3 and 6, which separates a correct mask from one that leaks them. Back-to-back errors separate a restarted hold from a hold that ends on time. A selected parity cycle whose data cycle had both chip selects high separates a tagged pipeline from an untagged one. Reset is asserted in the middle of a hold to show that it clears the flag without a clock edge.

// File: rtl/apc_pkg.sv
package apc_pkg;
   typedef enum logic {ROLE_FRONT = 1'b0, ROLE_BACK = 1'b1} apc_role_e;

   typedef struct packed {
      logic dpar;
      logic vld;
   } apc_stage_t;
endpackage

// File: rtl/apc_masked_parity.sv
module apc_masked_parity #(
   parameter int                 W    = 14,
   parameter logic [W-1:0]       KEEP = 14'h3FB6
) (
   input  logic [W-1:0] data,
   output logic         par
);
   generate
      if (W < 1) begin : g_bad_w
         $error("apc_masked_parity: W must be positive");
      end
      if (KEEP == {W{1'b1}}) begin : g_full
         assign par = ^data;
      end else begin : g_masked
         logic [W-1:0] kept;
         assign kept = data & KEEP;
         assign par  = ^kept;
      end
   endgenerate
endmodule

// File: rtl/apc_tag_delay.sv
module apc_tag_delay
   import apc_pkg::*;
#(
   parameter int LAT_FRONT = 1,
   parameter int LAT_BACK  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  apc_role_e  role,
   input  apc_stage_t in_stage,
   output apc_stage_t tap
);
   localparam int DEPTH = LAT_BACK;

   generate
      if (LAT_FRONT < 1 || LAT_BACK <= LAT_FRONT) begin : g_bad_lat
         $error("apc_tag_delay: need 1 <= LAT_FRONT < LAT_BACK");
      end
   endgenerate

   logic [DEPTH-1:0] dpar_sr;
   logic [DEPTH-1:0] vld_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dpar_sr <= '0;
         vld_sr  <= '0;
      end else begin
         dpar_sr <= {dpar_sr[DEPTH-2:0], in_stage.dpar};
         vld_sr  <= {vld_sr[DEPTH-2:0],  in_stage.vld};
      end
   end

   always_comb begin
      if (role == ROLE_BACK) begin
         tap.dpar = dpar_sr[LAT_BACK-1];
         tap.vld  = vld_sr[LAT_BACK-1];
      end else begin
         tap.dpar = dpar_sr[LAT_FRONT-1];
         tap.vld  = vld_sr[LAT_FRONT-1];
      end
   end
endmodule

// File: rtl/apc_err_hold.sv
module apc_err_hold #(
   parameter int HOLD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic hit,
   output logic err_n
);
   localparam int              CNT_W  = $clog2(HOLD + 1);
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD - 1);

   generate
      if (HOLD < 1) begin : g_bad_hold
         $error("apc_err_hold: HOLD must be at least 1");
      end
   endgenerate

   logic             err_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
         cnt_q <= '0;
      end else if (en) begin
         if (hit) begin
            err_q <= 1'b1;
            cnt_q <= RELOAD;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end else begin
            err_q <= 1'b0;
         end
      end
   end

   assign err_n = ~err_q;

   // R5: remaining hold count never exceeds the reload value
   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= RELOAD);

   // R6: a gated edge leaves the flag and the count unchanged
   assert_gate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(err_n) && $stable(cnt_q));

   generate
      if (HOLD >= 2) begin : g_min_low
         // R5: a freshly lowered flag is still low one edge later
         assert_min_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(err_n) |=> !err_n);
      end
   endgenerate
endmodule

// File: rtl/addr_parity_checker.sv
module addr_parity_checker
   import apc_pkg::*;
#(
   parameter int           BUS_W     = 14,
   parameter logic [BUS_W-1:0] CHECK_MASK = 14'h3FB6,
   parameter int           LAT_FRONT = 1,
   parameter int           LAT_BACK  = 2,
   parameter int           HOLD      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             role_back,
   input  logic             cs_a_n,
   input  logic             cs_b_n,
   input  logic [BUS_W-1:0] data_in,
   input  logic             par_in,
   output logic             ppo,
   output logic             err_n
);
   logic       cs_act;
   logic       data_par;
   apc_stage_t cap_stage;
   apc_stage_t tap;
   apc_role_e  role;
   logic       ppo_q;
   logic       fresh_q;
   logic       take;

   assign cs_act = ~(cs_a_n & cs_b_n);
   assign role   = apc_role_e'(role_back);

   apc_masked_parity #(.W(BUS_W), .KEEP(CHECK_MASK)) u_par (
      .data (data_in),
      .par  (data_par)
   );

   assign cap_stage.dpar = data_par;
   assign cap_stage.vld  = cs_act;

   apc_tag_delay #(.LAT_FRONT(LAT_FRONT), .LAT_BACK(LAT_BACK)) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .role     (role),
      .in_stage (cap_stage),
      .tap      (tap)
   );

   assign take = cs_act & tap.vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ppo_q   <= 1'b0;
         fresh_q <= 1'b0;
      end else begin
         fresh_q <= take;
         if (take) ppo_q <= tap.dpar ^ par_in;
      end
   end

   assign ppo = ppo_q;

   apc_err_hold #(.HOLD(HOLD)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cs_act),
      .hit   (fresh_q & ppo_q),
      .err_n (err_n)
   );

   // R6: both chip selects high at an edge freezes the partial parity
   assert_ppo_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_a_n && cs_b_n) |=> $stable(ppo));

   // R4: the flag only falls after a partial-parity value of 1
   assert_err_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_n) |-> $past(ppo));

   // R8: an uncompared cycle never moves the partial parity
   assert_no_untagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(ppo));
endmodule

// File: tb/addr_parity_checker_bench.sv
module addr_parity_checker_bench;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int              W    = 14;
   localparam logic [W-1:0]    USED = 14'h3FB6;
   localparam int              NV   = 20;
   // {cs_a_n, cs_b_n, par_in, data}
   localparam logic [16:0] VEC [NV] = '{
      {1'b0, 1'b0, 1'b0, 14'h0002}, {1'b0, 1'b1, 1'b0, 14'h0000},
      {1'b1, 1'b0, 1'b1, 14'h0006}, {1'b0, 1'b0, 1'b1, 14'h3FFF},
      {1'b0, 1'b0, 1'b0, 14'h1234}, {1'b1, 1'b1, 1'b1, 14'h2001},
      {1'b0, 1'b0, 1'b0, 14'h0010}, {1'b1, 1'b1, 1'b0, 14'h0000},
      {1'b0, 1'b1, 1'b1, 14'h0A0A}, {1'b0, 1'b0, 1'b0, 14'h0080},
      {1'b1, 1'b0, 1'b0, 14'h1FB0}, {1'b0, 1'b0, 1'b1, 14'h0049},
      {1'b0, 1'b0, 1'b0, 14'h3000}, {1'b1, 1'b1, 1'b0, 14'h0100},
      {1'b1, 1'b1, 1'b1, 14'h0000}, {1'b0, 1'b0, 1'b0, 14'h0022},
      {1'b0, 1'b1, 1'b0, 14'h0004}, {1'b0, 1'b0, 1'b1, 14'h2BCD},
      {1'b0, 1'b0, 1'b0, 14'h0000}, {1'b0, 1'b0, 1'b0, 14'h0000}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         role = 1'b0;
   logic         csa = 1'b1;
   logic         csb = 1'b1;
   logic         par = 1'b0;
   logic [W-1:0] d = '0;
   logic         ppo;
   logic         err_n;

   always #2.5 clk = ~clk;

   addr_parity_checker u_addr_parity_checker (
      .clk       (clk),
      .rst_n     (rst_n),
      .role_back (role),
      .cs_a_n    (csa),
      .cs_b_n    (csb),
      .data_in   (d),
      .par_in    (par),
      .ppo       (ppo),
      .err_n     (err_n)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   bit       m_ppo, m_err_n, m_fresh;
   int       m_cnt;
   bit [1:0] h_act, h_dp;

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      m_ppo = 1'b0; m_err_n = 1'b1; m_fresh = 1'b0; m_cnt = 0;
      h_act = '0; h_dp = '0;
   endtask

   task automatic do_reset(input bit r);
      @(negedge clk);
      rst_n = 1'b0; role = r; csa = 1'b1; csb = 1'b1; par = 1'b0; d = '0;
      model_clear();
      @(negedge clk);
      check("R1", "ppo in reset", ppo, 1'b0);
      check("R1", "err_n in reset", err_n, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // called at a falling edge; drives one cycle and compares after the next rise
   task automatic step(input bit a, input bit b, input bit p, input logic [W-1:0] dd, input string req);
      bit act, upd;
      int lat;
      csa = a; csb = b; par = p; d = dd;
      act = !(a && b);
      lat = role ? 2 : 1;
      upd = act && h_act[lat-1];
      if (act) begin
         if (m_fresh && m_ppo) begin m_err_n = 1'b0; m_cnt = 1; end
         else if (m_cnt > 0) m_cnt--;
         else m_err_n = 1'b1;
      end
      if (upd) m_ppo = h_dp[lat-1] ^ p;
      m_fresh = upd;
      h_act = {h_act[0], act};
      h_dp  = {h_dp[0], ^(dd & USED)};
      @(negedge clk);
      check(req, "ppo", ppo, m_ppo);
      check(req, "err_n", err_n, m_err_n);
   endtask

   task automatic idle(input string req);
      step(1'b0, 1'b0, 1'b0, '0, req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // table walk: R2 with front role, R3 with back role, R4 errors in both
      for (int r = 0; r < 2; r++) begin
         do_reset(r[0]);
         for (int i = 0; i < NV; i++)
            step(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13:0], r == 0 ? "R2/R4" : "R3/R4");
         for (int i = 0; i < 3; i++) idle("R4");
      end

      // R4 latency, front role: error two edges after data
      do_reset(1'b0);
      step(1'b0, 1'b0, 1'b0, 14'h0002, "R4");
      step(1'b0, 1'b0, 1'b0, 14'h0000, "R2");
      check("R2", "odd data par0 -> ppo", ppo, 1'b1);
      check("R4", "err_n before its edge", err_n, 1'b1);
      idle("R4");
      check("R4", "err_n low at data+2", err_n, 1'b0);
      idle("R5");
      check("R5", "err_n second low edge", err_n, 1'b0);
      idle("R5");
      check("R5", "err_n released after two", err_n, 1'b1);

      // R3/R4 latency, back role: error three edges after data
      do_reset(1'b1);
      step(1'b0, 1'b0, 1'b1, 14'h0010, "R3");
      step(1'b0, 1'b0, 1'b1, 14'h0000, "R3");
      check("R3", "ppo not yet updated", ppo, 1'b0);
      step(1'b0, 1'b0, 1'b0, 14'h0000, "R3");
      check("R3", "ppo at data+2", ppo, 1'b1);
      check("R4", "err_n still high at data+2", err_n, 1'b1);
      idle("R4");
      check("R4", "err_n low at data+3", err_n, 1'b0);

      // R5 restart: back-to-back errors keep the flag low for three edges
      do_reset(1'b0);
      step(1'b0, 1'b0, 1'b0, 14'h0002, "R5");
      step(1'b0, 1'b0, 1'b0, 14'h0004, "R5");
      idle("R5");
      idle("R5");
      idle("R5");
      check("R5", "restarted hold still low", err_n, 1'b0);
      idle("R5");
      check("R5", "restarted hold released", err_n, 1'b1);

      // R6: both chip selects high freeze flag and partial parity
      do_reset(1'b0);
      step(1'b0, 1'b0, 1'b0, 14'h0002, "R6");
      idle("R6");
      idle("R6");
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 14'h3FFF, "R6");
      check("R6", "err_n frozen low", err_n, 1'b0);
      check("R6", "ppo frozen", ppo, 1'b0);
      idle("R6");
      check("R6", "hold count resumed", err_n, 1'b0);
      idle("R6");
      check("R6", "hold ends after resume", err_n, 1'b1);

      // R8: data cycle with both selects high is not compared
      do_reset(1'b0);
      step(1'b1, 1'b1, 1'b0, 14'h0002, "R8");
      step(1'b0, 1'b0, 1'b0, 14'h0000, "R8");
      check("R8", "ppo unchanged", ppo, 1'b0);
      idle("R8");
      check("R8", "no error raised", err_n, 1'b1);

      // R7: only unchecked bits 0,3,6 set -> parity even
      do_reset(1'b0);
      step(1'b0, 1'b0, 1'b0, 14'h0049, "R7");
      step(1'b0, 1'b0, 1'b0, 14'h0000, "R7");
      check("R7", "ppo ignores bits 0,3,6", ppo, 1'b0);
      idle("R7");
      check("R7", "no error from bits 0,3,6", err_n, 1'b1);

      // R9: reset mid-hold clears the flag without a clock edge
      do_reset(1'b0);
      step(1'b0, 1'b0, 1'b0, 14'h0002, "R9");
      idle("R9");
      idle("R9");
      check("R9", "err_n low before reset", err_n, 1'b0);
      #1 rst_n = 1'b0;
      #0.5;
      check("R9", "err_n high on reset", err_n, 1'b1);
      check("R1", "ppo low on reset", ppo, 1'b0);
      model_clear();
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule